// File: doc/BRIEF.md
# Descriptor Ring Fetch Controller

This block pulls fixed-size work descriptors out of a circular ring in memory for a single independent context. Privileged setup supplies the base byte address of the ring and its size, given as a power-of-two exponent. Producer software writes entries into the ring and then rings a doorbell that carries its new write index. The block fetches the slot at its read index and waits for the memory response. It hands the descriptor downstream, bumps its read index, and repeats until the read index catches up with the last write index it was told about.

Both indices are free-running 64-bit counters. Ring position is derived from them only when an address is formed: the slot is the index modulo the ring size, and each slot is 64 bytes. A quiesce input parks the context between descriptors. Once parked, both indices can be saved from the outputs and loaded back through a restore strobe, so no context state is held only inside the block.

Top module: `desc_ring_fetch`

## Requirements
- R1: After reset, the read and write indices are zero, no memory request or descriptor is presented, `idle` is 1 and `dbErr` is 0.
- R2: The request address is `cfgBase + ((rdIdx mod 2^cfgSizeLog2) * 64)`, so slot addresses wrap to the ring base after the last slot.
- R3: A request is raised only while the read index differs from the write index. When the two are equal the block presents no request.
- R4: At most one read is outstanding. `memReqValid` and `memReqAddr` hold until `memReqReady`. No new request and no descriptor appear until `memRspValid` returns the data.
- R5: Descriptors leave in ring order. `descData` equals the response data and holds with `descValid` until `descReady`. The read index rises by exactly one on each accepted descriptor.
- R6: The write index changes only on a doorbell (or restore). A doorbell below the current write index but not below the read index is dropped silently. With no doorbell, no new work is fetched.
- R7: A doorbell whose write index is below the current read index leaves the write index unchanged and raises `dbErr` for exactly one cycle, in the cycle after the doorbell.
- R8: While `quiesce` is 1, the descriptor in flight completes, no further request is made, `idle` is 1 and the read index stays put. Dropping `quiesce` resumes fetching.
- R9: `restoreValid` loads both indices only while `idle` is 1. It is ignored while a fetch is in progress.
- R10: Indices never wrap at the ring boundary: after the slot wraps, the read index keeps counting upward past the ring size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBase | input | 64 | Ring base byte address |
| cfgSizeLog2 | input | 5 | Ring size as log2 of slot count |
| restoreValid | input | 1 | Load both indices (honoured when idle) |
| restoreRdIdx | input | 64 | Read index to restore |
| restoreWrIdx | input | 64 | Write index to restore |
| doorbellValid | input | 1 | Doorbell strobe |
| doorbellWrIdx | input | 64 | Write index carried by the doorbell |
| quiesce | input | 1 | Park between descriptors |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory read request accepted |
| memReqAddr | output | 64 | Byte address of the slot to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 512 | 64-byte read data |
| descValid | output | 1 | Descriptor available downstream |
| descReady | input | 1 | Downstream accepts descriptor |
| descData | output | 512 | Descriptor contents |
| rdIdx | output | 64 | Current read index |
| wrIdx | output | 64 | Last accepted write index |
| idle | output | 1 | Parked: no fetch in progress and none pending or quiesced |
| dbErr | output | 1 | One-cycle pulse on a doorbell behind the read index |

## Verification
The assertions assume a well-formed environment. Ring configuration is stable while a fetch is in progress. A response arrives only after the request was accepted. A restore never sets the read index above the write index, and software never posts more entries than the ring holds. The bench keeps to this: it changes the configuration and restores only while `idle` is high, and it answers each accepted request with exactly one response. Its doorbells run at most a ring's worth past the read index, except for the deliberately stale or backward doorbells that exercise the error and drop paths.

// File: rtl/ring_fetch_pkg.sv
package ring_fetch_pkg;
  localparam int DESC_BYTES = 64;
  localparam int DESC_W     = DESC_BYTES * 8;
  localparam int SLOT_SHIFT = $clog2(DESC_BYTES);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_ISSUE = 2'd3
  } fetch_state_t;

  // Strobes from the control FSM to the index/data datapath
  typedef struct packed {
    logic idxLoad;     // restore both indices
    logic wrLoad;      // take the doorbell write index
    logic rspCapture;  // latch memory response
    logic rdAdvance;   // descriptor accepted downstream
  } fetch_strobe_t;
endpackage

// File: rtl/ring_fetch_dp.sv
module ring_fetch_dp
  import ring_fetch_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 64,
  parameter int LOG2_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  fetch_strobe_t       strb,
  input  logic [ADDR_W-1:0]   cfgBase,
  input  logic [LOG2_W-1:0]   cfgSizeLog2,
  input  logic [IDX_W-1:0]    restoreRdIdx,
  input  logic [IDX_W-1:0]    restoreWrIdx,
  input  logic [IDX_W-1:0]    doorbellWrIdx,
  input  logic [DESC_W-1:0]   memRspData,
  output logic [IDX_W-1:0]    rdIdx,
  output logic [IDX_W-1:0]    wrIdx,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic [DESC_W-1:0]   descData,
  output logic                workAvail,
  output logic                dbBehind,
  output logic                dbStale
);
  logic [IDX_W-1:0] slotMask;
  logic [IDX_W-1:0] slotNum;
  logic [IDX_W-1:0] slotOffset;

  always_comb begin
    slotMask   = (IDX_W'(1) << cfgSizeLog2) - IDX_W'(1);
    slotNum    = rdIdx & slotMask;
    slotOffset = slotNum << SLOT_SHIFT;
    memReqAddr = cfgBase + ADDR_W'(slotOffset);
  end

  assign workAvail = (rdIdx != wrIdx);
  assign dbBehind  = (doorbellWrIdx < rdIdx);
  assign dbStale   = (doorbellWrIdx < wrIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdIdx <= '0;
      wrIdx <= '0;
    end else if (strb.idxLoad) begin
      rdIdx <= restoreRdIdx;
      wrIdx <= restoreWrIdx;
    end else begin
      if (strb.rdAdvance) rdIdx <= rdIdx + IDX_W'(1);
      if (strb.wrLoad)    wrIdx <= doorbellWrIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                descData <= '0;
    else if (strb.rspCapture) descData <= memRspData;
  end

  // the write index only moves forward outside a restore
  AST_WR_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.idxLoad |=> wrIdx >= $past(wrIdx)); // R6
endmodule

// File: rtl/ring_fetch_ctrl.sv
module ring_fetch_ctrl
  import ring_fetch_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          quiesce,
  input  logic          restoreValid,
  input  logic          doorbellValid,
  input  logic          workAvail,
  input  logic          dbBehind,
  input  logic          dbStale,
  input  logic          memReqReady,
  input  logic          memRspValid,
  input  logic          descReady,
  output fetch_strobe_t strb,
  output logic          memReqValid,
  output logic          descValid,
  output logic          idle,
  output logic          dbErr
);
  fetch_state_t state, stateNext;
  logic restoreTake;

  assign idle        = (state == ST_IDLE) && (quiesce || !workAvail);
  assign restoreTake = restoreValid && idle;
  assign memReqValid = (state == ST_REQ);
  assign descValid   = (state == ST_ISSUE);

  always_comb begin
    strb            = '0;
    strb.idxLoad    = restoreTake;
    strb.wrLoad     = doorbellValid && !dbBehind && !dbStale && !restoreTake;
    strb.rspCapture = (state == ST_WAIT) && memRspValid;
    strb.rdAdvance  = (state == ST_ISSUE) && descReady;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (!quiesce && workAvail) stateNext = ST_REQ;
      ST_REQ:   if (memReqReady)           stateNext = ST_WAIT;
      ST_WAIT:  if (memRspValid)           stateNext = ST_ISSUE;
      ST_ISSUE: if (descReady)             stateNext = ST_IDLE;
      default:                             stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      dbErr <= 1'b0;
    end else begin
      state <= stateNext;
      dbErr <= doorbellValid && dbBehind && !restoreTake;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid); // R4
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqReady |=> !memReqValid && !descValid); // R4
  AST_PARKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    quiesce && idle |=> !memReqValid && !descValid); // R8
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    dbErr && !(doorbellValid && dbBehind) |=> !dbErr); // R7
endmodule

// File: rtl/desc_ring_fetch.sv
module desc_ring_fetch
  import ring_fetch_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int IDX_W    = 64,
  parameter int MAX_LOG2 = 20,
  localparam int LOG2_W  = $clog2(MAX_LOG2 + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [LOG2_W-1:0] cfgSizeLog2,
  input  logic              restoreValid,
  input  logic [IDX_W-1:0]  restoreRdIdx,
  input  logic [IDX_W-1:0]  restoreWrIdx,
  input  logic              doorbellValid,
  input  logic [IDX_W-1:0]  doorbellWrIdx,
  input  logic              quiesce,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [DESC_W-1:0] memRspData,
  output logic              descValid,
  input  logic              descReady,
  output logic [DESC_W-1:0] descData,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [IDX_W-1:0]  wrIdx,
  output logic              idle,
  output logic              dbErr
);
  fetch_strobe_t strb;
  logic workAvail;
  logic dbBehind;
  logic dbStale;

  ring_fetch_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .quiesce      (quiesce),
    .restoreValid (restoreValid),
    .doorbellValid(doorbellValid),
    .workAvail    (workAvail),
    .dbBehind     (dbBehind),
    .dbStale      (dbStale),
    .memReqReady  (memReqReady),
    .memRspValid  (memRspValid),
    .descReady    (descReady),
    .strb         (strb),
    .memReqValid  (memReqValid),
    .descValid    (descValid),
    .idle         (idle),
    .dbErr        (dbErr)
  );

  ring_fetch_dp #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W),
    .LOG2_W(LOG2_W)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .cfgBase      (cfgBase),
    .cfgSizeLog2  (cfgSizeLog2),
    .restoreRdIdx (restoreRdIdx),
    .restoreWrIdx (restoreWrIdx),
    .doorbellWrIdx(doorbellWrIdx),
    .memRspData   (memRspData),
    .rdIdx        (rdIdx),
    .wrIdx        (wrIdx),
    .memReqAddr   (memReqAddr),
    .descData     (descData),
    .workAvail    (workAvail),
    .dbBehind     (dbBehind),
    .dbStale      (dbStale)
  );

  AST_REQ_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr)); // R4
  AST_DESC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !descReady |=> descValid && $stable(descData)); // R5
  AST_RD_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    descValid && descReady |=> rdIdx == $past(rdIdx) + IDX_W'(1)); // R5
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(descValid && descReady) && !idle |=> $stable(rdIdx)); // R8
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid || descValid |-> rdIdx != wrIdx); // R3
  AST_DB_BEHIND: assert property (@(posedge clk) disable iff (!rstN)
    doorbellValid && (doorbellWrIdx < rdIdx) && !(restoreValid && idle)
    |=> dbErr && $stable(wrIdx)); // R7
endmodule

// File: tb/tb_desc_ring_fetch.sv
`timescale 1ns/1ps
module tb_desc_ring_fetch;
  typedef struct packed {
    logic [63:0] base;
    logic [4:0]  lg;
    logic [63:0] start;
    logic [7:0]  cnt;
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VECS [NVEC] = '{
    '{64'h0000_1000, 5'd2, 64'd0,            8'd3},  // plain run
    '{64'h0000_1000, 5'd2, 64'd3,            8'd3},  // slot wraps 3,0,1
    '{64'h0008_0000, 5'd4, 64'h1_0000_000E,  8'd4},  // wide index, wrap
    '{64'h00AB_C000, 5'd0, 64'd5,            8'd2}   // single-slot ring
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [63:0]  cfgBase = '0;
  logic [4:0]   cfgSizeLog2 = '0;
  logic         restoreValid = 1'b0;
  logic [63:0]  restoreRdIdx = '0;
  logic [63:0]  restoreWrIdx = '0;
  logic         doorbellValid = 1'b0;
  logic [63:0]  doorbellWrIdx = '0;
  logic         quiesce = 1'b0;
  logic         memReqValid;
  logic         memReqReady = 1'b0;
  logic [63:0]  memReqAddr;
  logic         memRspValid = 1'b0;
  logic [511:0] memRspData = '0;
  logic         descValid;
  logic         descReady = 1'b0;
  logic [511:0] descData;
  logic [63:0]  rdIdx;
  logic [63:0]  wrIdx;
  logic         idle;
  logic         dbErr;

  int total = 0;
  int bad = 0;
  int serial = 0;

  always #2.5 clk = ~clk;

  desc_ring_fetch dut (
    .clk(clk), .rstN(rstN), .cfgBase(cfgBase), .cfgSizeLog2(cfgSizeLog2),
    .restoreValid(restoreValid), .restoreRdIdx(restoreRdIdx),
    .restoreWrIdx(restoreWrIdx), .doorbellValid(doorbellValid),
    .doorbellWrIdx(doorbellWrIdx), .quiesce(quiesce),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid),
    .memRspData(memRspData), .descValid(descValid), .descReady(descReady),
    .descData(descData), .rdIdx(rdIdx), .wrIdx(wrIdx), .idle(idle),
    .dbErr(dbErr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] slotAddr(input logic [63:0] base,
                                           input logic [4:0] lg,
                                           input logic [63:0] idx);
    return base + ((idx & ((64'd1 << lg) - 64'd1)) << 6);
  endfunction

  task automatic ringDoorbell(input logic [63:0] idx);
    doorbellValid = 1'b1;
    doorbellWrIdx = idx;
    @(negedge clk);
    doorbellValid = 1'b0;
  endtask

  task automatic doRestore(input logic [63:0] rd, input logic [63:0] wr);
    restoreValid = 1'b1;
    restoreRdIdx = rd;
    restoreWrIdx = wr;
    @(negedge clk);
    restoreValid = 1'b0;
  endtask

  // serve one fetch: check address, stall request and descriptor as asked
  task automatic serveOne(input logic [63:0] expAddr, input int reqStall,
                          input int descStall);
    logic [511:0] pat;
    while (!memReqValid) @(negedge clk);
    chk(memReqAddr == expAddr, "R2", "slot address", memReqAddr, expAddr);
    for (int s = 0; s < reqStall; s++) begin
      @(negedge clk);
      chk(memReqValid && memReqAddr == expAddr, "R4", "request held",
          memReqAddr, expAddr);
    end
    memReqReady = 1'b1;
    @(negedge clk);
    memReqReady = 1'b0;
    chk(!memReqValid && !descValid, "R4", "quiet while read outstanding",
        {62'd0, memReqValid, descValid}, 64'd0);
    serial++;
    pat = {8{expAddr ^ {32'hD15C_0000, 32'(serial)}}};
    memRspValid = 1'b1;
    memRspData  = pat;
    @(negedge clk);
    memRspValid = 1'b0;
    memRspData  = ~pat;
    while (!descValid) @(negedge clk);
    chk(descData == pat, "R5", "descriptor data", descData[63:0], pat[63:0]);
    for (int s = 0; s < descStall; s++) begin
      @(negedge clk);
      chk(descValid && descData == pat, "R5", "descriptor held",
          descData[63:0], pat[63:0]);
    end
    descReady = 1'b1;
    @(negedge clk);
    descReady = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] x;
    logic        sawReq;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rdIdx == 0, "R1", "rdIdx", rdIdx, 0);
    chk(wrIdx == 0, "R1", "wrIdx", wrIdx, 0);
    chk(!memReqValid && !descValid && idle && !dbErr, "R1", "outputs",
        {60'd0, memReqValid, descValid, idle, dbErr}, 64'd2);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      vec_t tv;
      tv = VECS[v];
      cfgBase     = tv.base;
      cfgSizeLog2 = tv.lg;
      doRestore(tv.start, tv.start);
      chk(rdIdx == tv.start && wrIdx == tv.start, "R9", "restore loads",
          rdIdx, tv.start);
      // R6: no doorbell, no work
      sawReq = 1'b0;
      repeat (4) begin @(negedge clk); sawReq |= memReqValid; end
      chk(!sawReq, "R6", "no fetch before doorbell", {63'd0, sawReq}, 0);
      ringDoorbell(tv.start + 64'(tv.cnt));
      for (int k = 0; k < int'(tv.cnt); k++)
        serveOne(slotAddr(tv.base, tv.lg, tv.start + 64'(k)), k % 2, (k + 1) % 2);
      chk(rdIdx == tv.start + 64'(tv.cnt), "R10", "index counts past ring",
          rdIdx, tv.start + 64'(tv.cnt));
      sawReq = 1'b0;
      repeat (6) begin @(negedge clk); sawReq |= memReqValid; end
      chk(!sawReq && idle, "R3", "stops at write index",
          {62'd0, sawReq, idle}, 64'd1);
    end

    // R7: doorbell behind read index
    x = rdIdx;
    ringDoorbell(x - 64'd1);
    chk(dbErr == 1'b1, "R7", "error pulse", {63'd0, dbErr}, 1);
    @(negedge clk);
    chk(dbErr == 1'b0, "R7", "pulse one cycle", {63'd0, dbErr}, 0);
    chk(wrIdx == x, "R7", "write index kept", wrIdx, x);

    // R6: stale doorbell (below write index, not below read index) dropped
    doRestore(x, x + 64'd2);
    ringDoorbell(x + 64'd1);
    chk(wrIdx == x + 64'd2 && !dbErr, "R6", "stale doorbell dropped",
        wrIdx, x + 64'd2);
    serveOne(slotAddr(cfgBase, cfgSizeLog2, x), 0, 0);
    serveOne(slotAddr(cfgBase, cfgSizeLog2, x + 64'd1), 0, 0);
    x = x + 64'd2;

    // R8: quiesce mid-flight
    ringDoorbell(x + 64'd3);
    while (!memReqValid) @(negedge clk);
    quiesce = 1'b1;
    serveOne(slotAddr(cfgBase, cfgSizeLog2, x), 0, 0);
    sawReq = 1'b0;
    repeat (10) begin @(negedge clk); sawReq |= memReqValid; end
    chk(!sawReq, "R8", "no request while quiesced", {63'd0, sawReq}, 0);
    chk(idle && rdIdx == x + 64'd1, "R8", "parked index", rdIdx, x + 64'd1);
    chk(wrIdx == x + 64'd3, "R8", "write index kept", wrIdx, x + 64'd3);
    quiesce = 1'b0;
    serveOne(slotAddr(cfgBase, cfgSizeLog2, x + 64'd1), 1, 0);
    serveOne(slotAddr(cfgBase, cfgSizeLog2, x + 64'd2), 0, 2);
    chk(rdIdx == x + 64'd3, "R8", "resumed to end", rdIdx, x + 64'd3);
    x = x + 64'd3;

    // R9: restore ignored while busy
    ringDoorbell(x + 64'd1);
    while (!memReqValid) @(negedge clk);
    doRestore(64'd0, 64'd0);
    serveOne(slotAddr(cfgBase, cfgSizeLog2, x), 0, 0);
    chk(rdIdx == x + 64'd1 && wrIdx == x + 64'd1, "R9", "busy restore ignored",
        rdIdx, x + 64'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule